// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns a single register write into a command for one CPU of a multi-core cluster. The written word carries a 2-bit command code, a target CPU number and a 6-bit vector. The four commands are:

- post an interrupt carrying the vector;
- apply a power-on reset and then let the core run;
- park the core so that interrupts do not wake it;
- resume the core.

Each CPU has a small state machine with three states:

- `CPU_HALT`: the core is parked.
- `CPU_RESET`: a one-cycle reset pulse is in progress.
- `CPU_RUN`: the core is allowed to execute.

Its transitions are:

- `go_reset`: an accepted power-on reset, from any state.
- `reset_done`: `CPU_RESET` to `CPU_RUN` one cycle later, unless a park or another reset arrives.
- `go_halt`: a park command, from any state.
- `go_run`: a resume command, from any state.
- `hold`: all other cycles.

A write names a CPU that does not exist when its target number is not below `NUM_CPU`. Such a write is dropped without any trace. A reset command is accepted only when its vector equals the parameter `POR_CODE`. A reset with any other vector is dropped and sets a sticky error flag. Only the block's reset clears that flag.

Top module: `ipi_dispatch`

## Requirements
- R1: Fields of `wr_word`: bits 17:16 hold the command code, bits 12:8 hold the target CPU, and bits 5:0 hold the vector. All other bits are ignored. Command codes are: 0 interrupt, 1 power-on reset, 2 park, 3 resume.
- R2: An interrupt command to CPU n raises `irq_post[n]` alone, for exactly the one cycle after the write edge, with `irq_vec` equal to the vector. It leaves `run_en` and `rst_req` unchanged. `irq_post` is never more than one-hot.
- R3: A reset command whose vector equals `POR_CODE` raises `rst_req[n]` for the one cycle after the write edge, with `run_en[n]` low in that cycle. In the following cycle `run_en[n]` is high, unless a new command to the same CPU overrides it.
- R4: A reset command with any other vector changes no CPU state. It sets `cmd_err`, which then stays high until reset.
- R5: A park command drops `run_en[n]` in the cycle after the write edge. Later interrupt commands to that CPU do not raise it again.
- R6: A resume command raises `run_en[n]` in the cycle after the write edge.
- R7: A write whose target is not below `NUM_CPU` changes no output and does not set `cmd_err`.
- R8: While reset is asserted and right after it is released: `run_en` is 1 for CPU 0 only, and `rst_req`, `irq_post` and `cmd_err` are all 0.
- R9: Cycles without `wr_en` change no CPU state, except for the automatic `CPU_RESET` to `CPU_RUN` step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Dispatch register write strobe |
| wr_word | input | 32 | Written command word |
| irq_post | output | NUM_CPU | One-cycle interrupt post, one bit per CPU |
| irq_vec | output | 6 | Vector of the posted interrupt |
| rst_req | output | NUM_CPU | One-cycle power-on reset request per CPU |
| run_en | output | NUM_CPU | Run enable per CPU |
| cmd_err | output | 1 | Sticky flag for a rejected reset vector |

## Verification
The bench builds the block with `NUM_CPU = 5` and `POR_CODE = 1`. With five CPUs the count is not a power of two, so targets 5 to 31 fit in the target field but do not exist. This exercises the discard path with values the field can actually encode. The bench also sends back-to-back commands to one CPU while it is still in its reset cycle. It sends words with every ignored bit set. It parks CPU 0, the one that starts out running.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int OP_LSB  = 16;
    localparam int TGT_LSB = 8;
    localparam int TGT_W   = 5;
    localparam int VEC_W   = 6;

    typedef enum logic [1:0] {
        OP_IRQ  = 2'd0,
        OP_POR  = 2'd1,
        OP_IDLE = 2'd2,
        OP_WAKE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CPU_HALT  = 2'd0,
        CPU_RESET = 2'd1,
        CPU_RUN   = 2'd2
    } cpu_state_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter logic [VEC_W-1:0] POR_CODE = 6'h01
) (
    input  logic               wr_en,
    input  logic [31:0]        wr_word,
    output logic [NUM_CPU-1:0] hit,
    output op_e                op,
    output logic [VEC_W-1:0]   vec,
    output logic               por_ok,
    output logic               por_bad
);
    logic [TGT_W-1:0] tgt;
    logic             in_range;

    always_comb begin
        op       = op_e'(wr_word[OP_LSB +: 2]);
        tgt      = wr_word[TGT_LSB +: TGT_W];
        vec      = wr_word[VEC_W-1:0];
        in_range = wr_en && ({1'b0, tgt} < (TGT_W+1)'(NUM_CPU));
        por_ok   = (vec == POR_CODE);
        por_bad  = in_range && (op == OP_POR) && !por_ok;
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_hit
        assign hit[i] = in_range && (tgt == TGT_W'(i));
    end
endmodule

// File: rtl/ipi_cpu_fsm.sv
module ipi_cpu_fsm
    import ipi_pkg::*;
#(
    parameter bit BOOT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  op_e  op,
    input  logic por_ok,
    output logic run_en,
    output logic rst_req
);
    localparam cpu_state_e INIT = BOOT ? CPU_RUN : CPU_HALT;

    cpu_state_e st, st_nx;

    always_comb begin
        st_nx = (st == CPU_RESET) ? CPU_RUN : st;   // reset_done / hold
        if (sel) begin
            unique case (op)
                OP_IRQ:  ;
                OP_POR:  if (por_ok) st_nx = CPU_RESET;  // go_reset
                OP_IDLE: st_nx = CPU_HALT;               // go_halt
                OP_WAKE: st_nx = CPU_RUN;                // go_run
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= INIT;
        else        st <= st_nx;
    end

    always_comb begin
        run_en  = 1'b0;
        rst_req = 1'b0;
        unique case (st)
            CPU_HALT:  ;
            CPU_RESET: rst_req = 1'b1;
            CPU_RUN:   run_en  = 1'b1;
            default:   ;
        endcase
    end

    assert_reset_then_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !sel) |=> (run_en && !rst_req));
    assert_reset_not_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && run_en));
    assert_halt_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !rst_req && !sel) |=> !run_en);
endmodule

// File: rtl/ipi_post_stage.sv
module ipi_post_stage
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] hit,
    input  op_e                op,
    input  logic [VEC_W-1:0]   vec,
    output logic [NUM_CPU-1:0] irq_post,
    output logic [VEC_W-1:0]   irq_vec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_post <= '0;
            irq_vec  <= '0;
        end else begin
            irq_post <= (op == OP_IRQ) ? hit : '0;
            if (op == OP_IRQ && |hit) irq_vec <= vec;
        end
    end

    assert_post_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_post));
    assert_post_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit && op == OP_IRQ) |=> (irq_post == $past(hit) && irq_vec == $past(vec)));
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter logic [5:0] POR_CODE = 6'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [31:0]        wr_word,
    output logic [NUM_CPU-1:0] irq_post,
    output logic [5:0]         irq_vec,
    output logic [NUM_CPU-1:0] rst_req,
    output logic [NUM_CPU-1:0] run_en,
    output logic               cmd_err
);
    logic [NUM_CPU-1:0] hit;
    op_e                op;
    logic [VEC_W-1:0]   vec;
    logic               por_ok, por_bad;

    ipi_decode #(.NUM_CPU(NUM_CPU), .POR_CODE(POR_CODE)) u_dec (
        .wr_en(wr_en), .wr_word(wr_word), .hit(hit), .op(op),
        .vec(vec), .por_ok(por_ok), .por_bad(por_bad)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        ipi_cpu_fsm #(.BOOT(i == 0)) u_fsm (
            .clk(clk), .rst_n(rst_n), .sel(hit[i]), .op(op),
            .por_ok(por_ok), .run_en(run_en[i]), .rst_req(rst_req[i])
        );
    end

    ipi_post_stage #(.NUM_CPU(NUM_CPU)) u_post (
        .clk(clk), .rst_n(rst_n), .hit(hit), .op(op), .vec(vec),
        .irq_post(irq_post), .irq_vec(irq_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_err <= 1'b0;
        else if (por_bad) cmd_err <= 1'b1;
    end

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);
    assert_out_of_range_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[12:8] >= 5'(NUM_CPU) && !(|rst_req))
        |=> ($stable(run_en) && irq_post == '0 && rst_req == '0 && $stable(cmd_err)));
    assert_idle_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(|rst_req)) |=> ($stable(run_en) && rst_req == '0));
endmodule

// File: tb/ipi_dispatch_test.sv
module ipi_dispatch_test;
    localparam int PERIOD = 10;
    localparam int N      = 5;
    localparam logic [5:0] POR = 6'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [N-1:0] irq_post, rst_req, run_en;
    logic [5:0] irq_vec;
    logic cmd_err;

    int checks = 0;
    int fails  = 0;
    int st [N];          // 0 halted, 1 in reset pulse, 2 running
    int m_post;
    int m_vec;
    int m_err;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    ipi_dispatch #(.NUM_CPU(N), .POR_CODE(POR)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .irq_post(irq_post), .irq_vec(irq_vec), .rst_req(rst_req),
        .run_en(run_en), .cmd_err(cmd_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int op, int tgt, int vec);
        return (32'(op) << 16) | (32'(tgt) << 8) | 32'(vec);
    endfunction

    task automatic compare(string tag);
        int er = 0, rr = 0;
        for (int i = 0; i < N; i++) begin
            if (st[i] == 2) er |= (1 << i);
            if (st[i] == 1) rr |= (1 << i);
        end
        chk(tag, "run_en", int'(run_en), er);
        chk(tag, "rst_req", int'(rst_req), rr);
        chk(tag, "irq_post", int'(irq_post), m_post);
        if (m_post != 0) chk(tag, "irq_vec", int'(irq_vec), m_vec);
        chk(tag, "cmd_err", int'(cmd_err), m_err);
    endtask

    task automatic step(string tag, bit we, logic [31:0] w);
        int op, t, v;
        @(negedge clk);
        wr_en = we;
        wr_word = w;
        @(posedge clk);
        op = int'(w[17:16]);
        t  = int'(w[12:8]);
        v  = int'(w[5:0]);
        m_post = 0;
        for (int i = 0; i < N; i++) if (st[i] == 1) st[i] = 2;
        if (we && t < N) begin
            case (op)
                0: begin m_post = 1 << t; m_vec = v; end
                1: if (v == int'(POR)) st[t] = 1; else m_err = 1;
                2: st[t] = 0;
                default: st[t] = 2;
            endcase
        end
        #1;
        compare(tag);
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) st[i] = (i == 0) ? 2 : 0;
        m_post = 0; m_vec = 0; m_err = 0;
        repeat (3) @(posedge clk);
        #1 compare("R8 in reset");
        @(negedge clk) rst_n = 1'b1;
        #1 compare("R8 after release");

        step("R2 irq cpu2", 1, mk(0, 2, 6'h2A));
        step("R2 post ends", 0, 0);
        step("R6 wake cpu1", 1, mk(3, 1, 0));
        step("R9 idle", 0, mk(2, 1, 0));
        step("R5 park cpu0", 1, mk(2, 0, 0));
        step("R5 irq parked cpu0", 1, mk(0, 0, 6'h11));
        step("R5 stays parked", 0, 0);
        step("R3 por cpu3", 1, mk(1, 3, POR));
        step("R3 por done", 0, 0);
        step("R4 bad por cpu4", 1, mk(1, 4, 6'h05));
        step("R4 err sticky", 0, 0);
        step("R7 target 5", 1, mk(3, 5, 0));
        step("R7 target 31 irq", 1, mk(0, 31, 6'h3F));
        step("R7 target 7 por", 1, mk(1, 7, POR));
        step("R3 por cpu4", 1, mk(1, 4, POR));
        step("R3 park in reset cpu4", 1, mk(2, 4, 0));
        step("R3 por cpu1 running", 1, mk(1, 1, POR));
        step("R3 por again cpu1", 1, mk(1, 1, POR));
        step("R3 irq during reset", 1, mk(0, 1, 6'h07));
        step("R1 ignored bits irq", 1, 32'hFFFC_E0C0 | mk(0, 4, 6'h15));
        step("R1 ignored bits wake", 1, 32'hFFFC_E0C0 | mk(3, 2, 6'h3F));
        step("R1 ignored bits por", 1, 32'hFFFC_E0C0 | mk(1, 0, POR));
        step("R9 settle", 0, 0);
        step("R2 irq cpu4 vec0", 1, mk(0, 4, 0));
        step("R9 final idle", 0, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule